// File: doc/BRIEF.md
# Row-Buffered DRAM Array Model

This block is a synthesizable model of a two-dimensional storage array. It holds a grid of multi-bit cells, arranged in rows and columns, and it is reached through one narrow address port that carries the row number and then the column number. A row command reads one whole row of the grid into an internal row buffer. After that, each column command picks one cell out of that buffer. A read returns the cell on the data output. A write changes the cell in the buffer and in the grid on the same clock edge.

Once a row is open, any number of column commands can follow it. Each one is served from the row buffer, so the grid is not read again. Memory-controller logic and bus-level benches can use the block as a stand-in for a real DRAM device. It models only the addressing and data flow. The cell physics, charge leakage and refresh are not modelled.

Top module: `dramrb_top`

## Requirements
- R1: After reset, `rd_data` is 0, `rd_valid` is 0 and `miss_err` is 0. No row is open, and every cell of the grid holds 0.
- R2: A row command (`row_stb`=1) latches the row number from `addr` and copies that whole row into the row buffer. Column reads that follow return the cells of that row.
- R3: A column read (`col_stb`=1, `wr_en`=0, `row_stb`=0) with a row open returns the addressed cell on `rd_data`. `rd_valid`=1 comes in the cycle after the command is sampled.
- R4: Several column reads in any column order may follow one row command, with no new row command between them. Each returns the right cell of the open row.
- R5: A column write (`col_stb`=1, `wr_en`=1, `row_stb`=0) with a row open updates the buffer cell and the grid cell on the same edge. An immediate read returns the new value. The value is still there after another row is opened and this row is opened again. A write never raises `rd_valid`.
- R6: A column command issued before any row command since reset raises `miss_err` for exactly one cycle, in the cycle after the command. If the command is a read, it also returns `rd_data`=0 with `rd_valid`=1. If it is a write, the write is dropped and the grid is left unchanged.
- R7: When `row_stb` and `col_stb` are both 1 in the same cycle, the row command is carried out and the column command is ignored. There is no `rd_valid`, no write and no error.
- R8: In a cycle after which no read was sampled, `rd_valid` is 0 and `rd_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_stb | input | 1 | Row command: open the row given on `addr` |
| col_stb | input | 1 | Column command: access the cell given on `addr` in the open row |
| wr_en | input | 1 | With `col_stb`: 1 means write, 0 means read |
| addr | input | AW (2) | Shared row/column number |
| wr_data | input | WIDTH (8) | Data to be written |
| rd_data | output | WIDTH (8) | Read data, registered |
| rd_valid | output | 1 | One-cycle pulse marking new `rd_data` |
| miss_err | output | 1 | One-cycle pulse: a column command arrived with no row open |

## Verification
Every result is registered once. The row buffer, the open-row state, `rd_data`, `rd_valid` and `miss_err` all change on the edge that samples the command. The bench drives each command on a falling edge, lets one rising edge pass, and then checks at the next falling edge. A read is therefore compared one cycle after it is issued, and a write becomes visible to the read that follows it straight away. The checks sweep all 16 cells of the 4x4 default through write and read passes. Reads are issued in reverse column order. The bench compares each result against a model array whose contents it computes from a formula of row and column.

// File: rtl/dramrb_pkg.sv
package dramrb_pkg;
  // number of index bits for n entries, never below one
  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // command decode result
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_ROW   = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } dram_cmd_e;

  function automatic dram_cmd_e decode_cmd(input logic row_s, input logic col_s, input logic we);
    if (row_s)     return CMD_ROW;
    else if (col_s) return we ? CMD_WRITE : CMD_READ;
    else           return CMD_IDLE;
  endfunction
endpackage

// File: rtl/dramrb_array.sv
module dramrb_array #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int WIDTH = 8,
  localparam int RAW  = dramrb_pkg::idx_bits(ROWS),
  localparam int CAW  = dramrb_pkg::idx_bits(COLS),
  localparam int LINE = COLS * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAW-1:0]   rd_row,
  output logic [LINE-1:0]  rd_line,
  input  logic             wr_en,
  input  logic [RAW-1:0]   wr_row,
  input  logic [CAW-1:0]   wr_col,
  input  logic [WIDTH-1:0] wr_data
);
  logic [LINE-1:0] mem [ROWS];

  function automatic logic [WIDTH-1:0] cell_of(input logic [LINE-1:0] line, input logic [CAW-1:0] col);
    return line[col*WIDTH +: WIDTH];
  endfunction

  logic rd_in_range;
  assign rd_in_range = ({1'b0, rd_row} < (RAW+1)'(ROWS));
  assign rd_line     = rd_in_range ? mem[rd_row] : '0;

  logic wr_in_range;
  assign wr_in_range = ({1'b0, wr_row} < (RAW+1)'(ROWS)) && ({1'b0, wr_col} < (CAW+1)'(COLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (wr_en && wr_in_range) begin
      mem[wr_row][wr_col*WIDTH +: WIDTH] <= wr_data;
    end
  end

  // R5: an accepted write lands in the grid on that edge
  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_in_range) |=> cell_of(mem[$past(wr_row)], $past(wr_col)) == $past(wr_data));
endmodule

// File: rtl/dramrb_rowbuf.sv
module dramrb_rowbuf #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int WIDTH = 8,
  localparam int RAW  = dramrb_pkg::idx_bits(ROWS),
  localparam int CAW  = dramrb_pkg::idx_bits(COLS),
  localparam int LINE = COLS * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RAW-1:0]   load_row,
  input  logic [LINE-1:0]  load_line,
  input  logic             wr_en,
  input  logic [CAW-1:0]   wr_col,
  input  logic [WIDTH-1:0] wr_data,
  output logic             open_o,
  output logic [RAW-1:0]   row_o,
  output logic [LINE-1:0]  line_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      row_o  <= '0;
      line_o <= '0;
    end else if (load) begin
      open_o <= 1'b1;
      row_o  <= load_row;
      line_o <= load_line;
    end else if (wr_en && open_o) begin
      line_o[wr_col*WIDTH +: WIDTH] <= wr_data;
    end
  end

  // R2: a row command opens exactly the requested row
  assert_row_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (open_o && row_o == $past(load_row)));
  // R2: once open, a row stays open until reset
  assert_open_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    open_o |=> open_o);
endmodule

// File: rtl/dramrb_colpath.sv
module dramrb_colpath #(
  parameter int COLS  = 4,
  parameter int WIDTH = 8,
  localparam int CAW  = dramrb_pkg::idx_bits(COLS),
  localparam int LINE = COLS * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic             col_req,
  input  logic             row_open,
  input  logic [CAW-1:0]   col,
  input  logic [LINE-1:0]  line,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             miss_err
);
  function automatic logic [WIDTH-1:0] pick(input logic [LINE-1:0] l, input logic [CAW-1:0] c);
    return ({1'b0, c} < (CAW+1)'(COLS)) ? l[c*WIDTH +: WIDTH] : '0;
  endfunction

  logic miss_evt;
  assign miss_evt = col_req && !row_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      miss_err <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      miss_err <= miss_evt;
      if (rd_req) rd_data <= row_open ? pick(line, col) : '0;
    end
  end

  // R6: a read with no open row returns zero
  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !row_open) |=> (rd_data == '0 && miss_err));
  // R8: data holds between reads
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_data));
endmodule

// File: rtl/dramrb_top.sv
module dramrb_top #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int WIDTH = 8,
  localparam int RAW  = dramrb_pkg::idx_bits(ROWS),
  localparam int CAW  = dramrb_pkg::idx_bits(COLS),
  localparam int AW   = dramrb_pkg::max2(RAW, CAW),
  localparam int LINE = COLS * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_stb,
  input  logic             col_stb,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             miss_err
);
  import dramrb_pkg::*;

  // named internal events
  dram_cmd_e cmd;
  logic ev_row, ev_col, ev_read, ev_write_ok;
  logic row_open;
  logic [RAW-1:0]  open_row;
  logic [LINE-1:0] array_line, buf_line;
  logic [RAW-1:0]  row_field;
  logic [CAW-1:0]  col_field;

  assign cmd         = decode_cmd(row_stb, col_stb, wr_en);
  assign ev_row      = (cmd == CMD_ROW);
  assign ev_read     = (cmd == CMD_READ);
  assign ev_col      = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign ev_write_ok = (cmd == CMD_WRITE) && row_open;
  assign row_field   = addr[RAW-1:0];
  assign col_field   = addr[CAW-1:0];

  dramrb_array #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_row(row_field), .rd_line(array_line),
    .wr_en(ev_write_ok), .wr_row(open_row), .wr_col(col_field), .wr_data(wr_data)
  );

  dramrb_rowbuf #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_rowbuf (
    .clk(clk), .rst_n(rst_n),
    .load(ev_row), .load_row(row_field), .load_line(array_line),
    .wr_en(ev_write_ok), .wr_col(col_field), .wr_data(wr_data),
    .open_o(row_open), .row_o(open_row), .line_o(buf_line)
  );

  dramrb_colpath #(.COLS(COLS), .WIDTH(WIDTH)) u_colpath (
    .clk(clk), .rst_n(rst_n),
    .rd_req(ev_read), .col_req(ev_col), .row_open(row_open),
    .col(col_field), .line(buf_line),
    .rd_data(rd_data), .rd_valid(rd_valid), .miss_err(miss_err)
  );

  // R3: every accepted read is answered one cycle later
  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb && !row_stb && !wr_en) |=> rd_valid);
  // R5 / R8: no read sampled means no valid pulse
  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(col_stb && !row_stb && !wr_en) |=> !rd_valid);
  // R7: a row command in the same cycle suppresses the column side
  assert_row_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |=> (!rd_valid && !miss_err));
  // R6: a column command with no row open flags an error
  assert_miss_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb && !row_stb && !row_open) |=> miss_err);
  // R6: the error is a single-cycle pulse
  assert_miss_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err |=> !miss_err || $past(col_stb && !row_stb && !row_open));
endmodule

// File: tb/tb_dramrb_top.sv
module tb_dramrb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_stb = 1'b0, col_stb = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rd_valid, miss_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NR][NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  dramrb_top dut (
    .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .col_stb(col_stb), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .miss_err(miss_err)
  );

  function automatic logic [7:0] pattern(input int r, input int c);
    return 8'((r * 37) + (c * 11) + 8'h5A);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic step(input logic rs, input logic cs, input logic we, input logic [1:0] a, input logic [7:0] d);
    row_stb = rs; col_stb = cs; wr_en = we; addr = a; wr_data = d;
    @(negedge clk);
    row_stb = 1'b0; col_stb = 1'b0; wr_en = 1'b0;
  endtask

  task automatic read_chk(input int c, input logic [7:0] exp, input string tag);
    step(1'b0, 1'b1, 1'b0, 2'(c), 8'h00);
    check({31'd0, rd_valid}, 32'd1, {tag, " valid"});
    check({24'd0, rd_data}, {24'd0, exp}, {tag, " data"});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) model[r][c] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({24'd0, rd_data}, 0, "R1 rd_data");
    check({31'd0, rd_valid}, 0, "R1 rd_valid");
    check({31'd0, miss_err}, 0, "R1 miss_err");

    // R6 read with no open row
    step(1'b0, 1'b1, 1'b0, 2'd2, 8'h00);
    check({31'd0, miss_err}, 1, "R6 read miss err");
    check({31'd0, rd_valid}, 1, "R6 read miss valid");
    check({24'd0, rd_data}, 0, "R6 read miss data");
    step(1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    check({31'd0, miss_err}, 0, "R6 err pulse ends");
    // R6 write with no open row is dropped
    step(1'b0, 1'b1, 1'b1, 2'd1, 8'h55);
    check({31'd0, miss_err}, 1, "R6 write miss err");
    check({31'd0, rd_valid}, 0, "R6 write miss no valid");
    step(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    read_chk(1, 8'h00, "R1 R6 grid zero after dropped write");

    // R5 fill every cell through column writes
    for (int r = 0; r < NR; r++) begin
      step(1'b1, 1'b0, 1'b0, 2'(r), 8'h00);
      for (int c = 0; c < NC; c++) begin
        step(1'b0, 1'b1, 1'b1, 2'(c), pattern(r, c));
        model[r][c] = pattern(r, c);
        check({31'd0, rd_valid}, 0, "R5 write no valid");
      end
    end

    // R2 R3 R4 reopen each row, read columns in reverse order
    for (int r = NR - 1; r >= 0; r--) begin
      step(1'b1, 1'b0, 1'b0, 2'(r), 8'h00);
      for (int c = NC - 1; c >= 0; c--)
        read_chk(c, model[r][c], "R2 R3 R4 sweep");
    end

    // R5 overwrite then immediate read, persistence across rows
    step(1'b1, 1'b0, 1'b0, 2'd2, 8'h00);
    step(1'b0, 1'b1, 1'b1, 2'd3, 8'hC3);
    model[2][3] = 8'hC3;
    read_chk(3, 8'hC3, "R5 immediate readback");
    step(1'b1, 1'b0, 1'b0, 2'd1, 8'h00);
    read_chk(3, model[1][3], "R5 other row untouched");
    step(1'b1, 1'b0, 1'b0, 2'd2, 8'h00);
    read_chk(3, 8'hC3, "R5 persists after reopen");

    // R7 simultaneous row and column write
    step(1'b1, 1'b1, 1'b1, 2'd0, 8'hEE);
    check({31'd0, rd_valid}, 0, "R7 no valid");
    check({31'd0, miss_err}, 0, "R7 no err");
    read_chk(0, model[0][0], "R7 row 0 opened, no write");
    step(1'b1, 1'b0, 1'b0, 2'd2, 8'h00);
    read_chk(0, model[2][0], "R7 old row untouched");
    // R7 simultaneous row and column read
    step(1'b1, 1'b1, 1'b0, 2'd3, 8'h00);
    check({31'd0, rd_valid}, 0, "R7 read suppressed");
    check({24'd0, rd_data}, {24'd0, model[2][0]}, "R7 data held");

    // R8 hold while idle
    step(1'b0, 1'b0, 1'b0, 2'd1, 8'h77);
    check({31'd0, rd_valid}, 0, "R8 idle no valid");
    check({24'd0, rd_data}, {24'd0, model[2][0]}, "R8 idle data held");

    finish_run();
  end
endmodule